// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block decides which of five hardware interrupt requests a processor core takes, and when. One request is non-maskable. Three are restart requests, and each has its own mask bit. The fifth is a general request that has no fixed target. For that one, external logic must supply the instruction, in reply to an active-low acknowledge. The core asserts a sampling strobe at the point in each instruction where requests may be taken. At that strobe the controller applies each line's trigger rule, the masks and the global enable. It then grants the eligible request of highest priority.

After a grant the controller reports the winning source as a one-hot code, together with its 16-bit target address. A grant of any kind clears the global enable. A pending bus-hold request at the strobe defers every grant, so the hold is serviced first and the non-maskable request is taken at a later strobe. A mask-write port updates the restart masks and can discard a captured edge. A status port shows which restart requests are pending. A small combinational path converts a software restart number into its target address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When several sources are eligible at one strobe, exactly one is granted, in this order from highest to lowest: non-maskable, restart-high, restart-mid, restart-low, general. In `src_o` these sources are bit 0, bit 1, bit 2, bit 3 and bit 4.
- R2: The target address on `vec_o` is 0x0024 for non-maskable, 0x003C for restart-high, 0x0034 for restart-mid, 0x002C for restart-low and 0x0000 for general. A general grant drives `ext_ack_n_o` low.
- R3: A grant is decided at the clock edge where `sample_i` is high. `take_o`, `src_o`, `vec_o` and `ext_ack_n_o` show it in the following cycle. `take_o` and the low acknowledge last one cycle. `src_o` and `vec_o` hold until the next grant.
- R4: The non-maskable line is granted only after a rising edge, and only if it is still high at the strobe. Masks and the global enable have no effect on it. It is not granted again until it has fallen and risen again.
- R5: A rising edge on `edge_hi_i` sets a latch that stays set after the input falls. The latch clears on its own grant, on reset, or when a mask word is written with bit 4 set.
- R6: Restart-mid, restart-low and general are level-sensitive. They are granted only if high at the strobe.
- R7: The global enable (`ien_o`) is 0 after reset. `en_cmd_i` sets it. `dis_cmd_i` clears it, and it also clears when any request is granted. While it is 0, the four maskable sources are never granted.
- R8: A mask word (`mask_wr_i`) loads bits 2:0 into the masks only when its bit 3 is 1. Bit 2 masks restart-high, bit 1 masks restart-mid and bit 0 masks restart-low. A masked source is not granted. Reset sets all three mask bits.
- R9: `pend_o` shows the high latch in bit 2, the mid input in bit 1 and the low input in bit 0, whatever the mask state.
- R10: At a strobe taken with `hold_i` high, nothing is granted. An armed non-maskable request stays armed and is granted at a later strobe without hold.
- R11: `swi_vec_o` equals `swi_num_i` times 8, for numbers 0 through 7.
- R12: After reset, `take_o` is 0, `ext_ack_n_o` is 1, `src_o` and `vec_o` are 0, masks are 3'b111 and the high latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Request sampling strobe from the core |
| hold_i | input | 1 | Bus-hold request, defers grants |
| nmi_i | input | 1 | Non-maskable request |
| edge_hi_i | input | 1 | Restart-high request, edge-latched |
| lvl_mid_i | input | 1 | Restart-mid request, level |
| lvl_lo_i | input | 1 | Restart-low request, level |
| ext_req_i | input | 1 | General request, level |
| en_cmd_i | input | 1 | Set global enable |
| dis_cmd_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask-word write strobe |
| mask_wdata_i | input | 5 | Mask word: [4] clear latch, [3] set-enable, [2:0] masks |
| swi_num_i | input | 3 | Software restart number |
| take_o | output | 1 | Grant pulse |
| src_o | output | 5 | One-hot granted source |
| vec_o | output | 16 | Target address of granted source |
| ext_ack_n_o | output | 1 | Active-low acknowledge for general grant |
| ien_o | output | 1 | Global enable state |
| mask_o | output | 3 | Current mask bits |
| pend_o | output | 3 | Pending status |
| swi_vec_o | output | 16 | Software restart target address |

## Verification
Grant results appear exactly one clock after the strobe edge, so the bench drives the strobe for one cycle and reads `take_o`, `src_o`, `vec_o` and the acknowledge just after that edge. It checks the acknowledge again one cycle later to confirm it has returned high. Edge captures need one edge to register, so the bench leaves a cycle between raising an edge-triggered line and its strobe, and it reads `pend_o` after the capturing edge. Mask, enable and latch-clear updates are visible one cycle after their write. The software restart address is combinational and is read in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int VEC_W   = 16;
  localparam int MWORD_W = 5;
  localparam int NMASK   = 3;

  localparam int S_NMI = 0;
  localparam int S_HI  = 1;
  localparam int S_MID = 2;
  localparam int S_LO  = 3;
  localparam int S_EXT = 4;

  localparam int MW_CLR = 4;
  localparam int MW_SET = 3;

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    case (idx)
      S_NMI:   return 16'h0024;
      S_HI:    return 16'h003C;
      S_MID:   return 16'h0034;
      S_LO:    return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic edge_i,
  input  logic nmi_take,
  input  logic hi_clr,
  output logic nmi_live,
  output logic hi_pend
);
  logic nmi_q, edge_q, armed_q, hi_q;
  logic armed_d, hi_d;

  always_comb begin
    armed_d = nmi_i & ((armed_q & ~nmi_take) | ~nmi_q);
    hi_d    = hi_clr ? 1'b0 : (hi_q | (edge_i & ~edge_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q   <= 1'b0;
      edge_q  <= 1'b0;
      armed_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      nmi_q   <= nmi_i;
      edge_q  <= edge_i;
      armed_q <= armed_d;
      hi_q    <= hi_d;
    end
  end

  assign nmi_live = armed_q & nmi_i;
  assign hi_pend  = hi_q;

  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q && !hi_clr |=> hi_q); // R5
  AST_NMI_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> !nmi_live); // R4
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  assign gnt[0] = req[0];
  for (genvar i = 1; i < N; i++) begin : g_pick
    assign gnt[i] = req[i] & ~(|req[i-1:0]);
  end
  assign any = |req;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int SWI_W     = 3,
  parameter int SWI_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic                 hold_i,
  input  logic                 nmi_i,
  input  logic                 edge_hi_i,
  input  logic                 lvl_mid_i,
  input  logic                 lvl_lo_i,
  input  logic                 ext_req_i,
  input  logic                 en_cmd_i,
  input  logic                 dis_cmd_i,
  input  logic                 mask_wr_i,
  input  logic [MWORD_W-1:0]   mask_wdata_i,
  input  logic [SWI_W-1:0]     swi_num_i,
  output logic                 take_o,
  output logic [NSRC-1:0]      src_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 ext_ack_n_o,
  output logic                 ien_o,
  output logic [NMASK-1:0]     mask_o,
  output logic [NMASK-1:0]     pend_o,
  output logic [VEC_W-1:0]     swi_vec_o
);
  logic srst_n;
  logic nmi_live, hi_pend, nmi_take, hi_clr;
  logic [NSRC-1:0] req, gnt;
  logic any, accept;
  logic [VEC_W-1:0] vec_pick;

  logic                ien_q, ien_d;
  logic [NMASK-1:0]    mask_q, mask_d;
  logic                take_q, take_d;
  logic [NSRC-1:0]     src_q, src_d;
  logic [VEC_W-1:0]    vec_q, vec_d;
  logic                ack_q, ack_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irq_capture u_cap (
    .clk      (clk),
    .rst_n    (srst_n),
    .nmi_i    (nmi_i),
    .edge_i   (edge_hi_i),
    .nmi_take (nmi_take),
    .hi_clr   (hi_clr),
    .nmi_live (nmi_live),
    .hi_pend  (hi_pend)
  );

  always_comb begin
    req        = '0;
    req[S_NMI] = nmi_live;
    req[S_HI]  = hi_pend   & ~mask_q[2] & ien_q;
    req[S_MID] = lvl_mid_i & ~mask_q[1] & ien_q;
    req[S_LO]  = lvl_lo_i  & ~mask_q[0] & ien_q;
    req[S_EXT] = ext_req_i & ien_q;
  end

  irq_prio_pick #(.N(NSRC)) u_pick (
    .req (req),
    .gnt (gnt),
    .any (any)
  );

  always_comb begin
    vec_pick = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt[i]) vec_pick = vec_pick | src_vector(i);
    end
  end

  assign accept   = sample_i & ~hold_i & any;
  assign nmi_take = accept & gnt[S_NMI];
  assign hi_clr   = (accept & gnt[S_HI]) | (mask_wr_i & mask_wdata_i[MW_CLR]);

  always_comb begin
    take_d = accept;
    ack_d  = accept & gnt[S_EXT];
    src_d  = accept ? gnt : src_q;
    vec_d  = accept ? vec_pick : vec_q;
    if (accept)         ien_d = 1'b0;
    else if (dis_cmd_i) ien_d = 1'b0;
    else if (en_cmd_i)  ien_d = 1'b1;
    else                ien_d = ien_q;
    mask_d = (mask_wr_i & mask_wdata_i[MW_SET]) ? mask_wdata_i[NMASK-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      src_q  <= '0;
      vec_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      mask_q <= mask_d;
      take_q <= take_d;
      ack_q  <= ack_d;
      src_q  <= src_d;
      vec_q  <= vec_d;
    end
  end

  assign take_o      = take_q;
  assign src_o       = src_q;
  assign vec_o       = vec_q;
  assign ext_ack_n_o = ~ack_q;
  assign ien_o       = ien_q;
  assign mask_o      = mask_q;
  assign pend_o      = {hi_pend, lvl_mid_i, lvl_lo_i};
  assign swi_vec_o   = VEC_W'(swi_num_i) << SWI_SHIFT;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!srst_n)
    take_o |-> $countones(src_o) == 1); // R1
  AST_ACK_PAIR: assert property (@(posedge clk) disable iff (!srst_n)
    !ext_ack_n_o |-> take_o && src_o[S_EXT]); // R2
  AST_IEN_DROP: assert property (@(posedge clk) disable iff (!srst_n)
    take_o |-> !ien_o); // R7
  AST_HOLD_DEFER: assert property (@(posedge clk) disable iff (!srst_n)
    sample_i && hold_i |=> !take_o); // R10
  AST_MID_MASKED: assert property (@(posedge clk) disable iff (!srst_n)
    sample_i && mask_o[1] |=> !(take_o && src_o[S_MID])); // R8
  AST_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    take_o && !sample_i |=> !take_o); // R3
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sample_i, hold_i, nmi_i, edge_hi_i, lvl_mid_i, lvl_lo_i, ext_req_i;
  logic        en_cmd_i, dis_cmd_i, mask_wr_i;
  logic [4:0]  mask_wdata_i;
  logic [2:0]  swi_num_i;
  logic        take_o, ext_ack_n_o, ien_o;
  logic [4:0]  src_o;
  logic [15:0] vec_o, swi_vec_o;
  logic [2:0]  mask_o, pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .hold_i(hold_i), .nmi_i(nmi_i),
    .edge_hi_i(edge_hi_i), .lvl_mid_i(lvl_mid_i), .lvl_lo_i(lvl_lo_i), .ext_req_i(ext_req_i),
    .en_cmd_i(en_cmd_i), .dis_cmd_i(dis_cmd_i), .mask_wr_i(mask_wr_i),
    .mask_wdata_i(mask_wdata_i), .swi_num_i(swi_num_i), .take_o(take_o), .src_o(src_o),
    .vec_o(vec_o), .ext_ack_n_o(ext_ack_n_o), .ien_o(ien_o), .mask_o(mask_o),
    .pend_o(pend_o), .swi_vec_o(swi_vec_o)
  );

  // fields: [10:8] mask word bits, [7] mid, [6] lo, [5] general, [4:0] expected src (R1 R6 R8)
  localparam logic [10:0] TBL [0:7] = '{
    11'b000_111_00100,
    11'b000_011_01000,
    11'b000_001_10000,
    11'b010_110_01000,
    11'b011_111_10000,
    11'b011_110_00000,
    11'b000_000_00000,
    11'b001_011_10000
  };

  function automatic logic [15:0] exp_vec(input logic [4:0] s);
    case (s)
      5'b00001: return 16'h0024;
      5'b00010: return 16'h003C;
      5'b00100: return 16'h0034;
      5'b01000: return 16'h002C;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe();
    sample_i = 1'b1;
    cyc();
    sample_i = 1'b0;
  endtask

  task automatic enable();
    en_cmd_i = 1'b1;
    cyc();
    en_cmd_i = 1'b0;
  endtask

  task automatic mword(input logic [4:0] w);
    mask_wr_i = 1'b1;
    mask_wdata_i = w;
    cyc();
    mask_wr_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    {sample_i, hold_i, nmi_i, edge_hi_i, lvl_mid_i, lvl_lo_i, ext_req_i} = '0;
    {en_cmd_i, dis_cmd_i, mask_wr_i} = '0;
    mask_wdata_i = '0;
    swi_num_i = '0;
    do_reset();

    // R12 reset state
    chk("R12 take", take_o, 0);
    chk("R12 ack_n", ext_ack_n_o, 1);
    chk("R12 src", src_o, 0);
    chk("R12 vec", vec_o, 0);
    chk("R12 ien", ien_o, 0);
    chk("R12 mask", mask_o, 3'b111);
    chk("R12 latch", pend_o[2], 0);

    // R11 software restart address
    for (int n = 0; n < 8; n++) begin
      swi_num_i = 3'(n);
      #1;
      chk("R11 swi", swi_vec_o, n * 8);
    end

    // table of level patterns: R1 R6 R8 R3
    for (int k = 0; k < 8; k++) begin
      mword({2'b01, TBL[k][10:8]});
      enable();
      lvl_mid_i = TBL[k][7];
      lvl_lo_i  = TBL[k][6];
      ext_req_i = TBL[k][5];
      strobe();
      if (TBL[k][4:0] == 5'b0) begin
        chk("R8 no grant", take_o, 0);
      end else begin
        chk("R3 take", take_o, 1);
        chk("R1 src", src_o, TBL[k][4:0]);
        chk("R2 vec", vec_o, exp_vec(TBL[k][4:0]));
        chk("R2 ack", ext_ack_n_o, TBL[k][4] ? 0 : 1);
      end
      {lvl_mid_i, lvl_lo_i, ext_req_i} = '0;
      cyc();
    end

    // R4 non-maskable ignores masks and enable
    mword(5'b01111);
    chk("R7 ien low", ien_o, 0);
    nmi_i = 1'b1;
    cyc();
    strobe();
    chk("R4 take", take_o, 1);
    chk("R4 src", src_o, 5'b00001);
    chk("R2 nmi vec", vec_o, 16'h0024);
    strobe();
    chk("R4 no retake on level", take_o, 0);
    nmi_i = 1'b0; cyc();
    nmi_i = 1'b1; cyc();
    nmi_i = 1'b0; cyc();
    strobe();
    chk("R4 dropped before strobe", take_o, 0);

    // R5 R9 edge latch, masked
    mword(5'b01100);
    edge_hi_i = 1'b1; cyc();
    edge_hi_i = 1'b0; cyc();
    chk("R5 latch holds", pend_o[2], 1);
    enable();
    strobe();
    chk("R8 hi masked", take_o, 0);
    chk("R9 pend masked", pend_o[2], 1);
    mword(5'b10000);
    chk("R5 clear bit", pend_o[2], 0);
    chk("R8 set-enable off", mask_o, 3'b100);
    mword(5'b01000);
    edge_hi_i = 1'b1; cyc();
    edge_hi_i = 1'b0; cyc();
    strobe();
    chk("R5 hi take", src_o, 5'b00010);
    chk("R2 hi vec", vec_o, 16'h003C);
    chk("R5 cleared by grant", pend_o[2], 0);

    // R1 full priority chain
    enable();
    {nmi_i, edge_hi_i, lvl_mid_i, lvl_lo_i, ext_req_i} = 5'b11111;
    cyc();
    edge_hi_i = 1'b0;
    chk("R9 pend all", pend_o, 3'b111);
    strobe();
    chk("R1 nmi first", src_o, 5'b00001);
    enable();
    strobe();
    chk("R1 hi second", src_o, 5'b00010);
    enable();
    strobe();
    chk("R1 mid third", src_o, 5'b00100);
    {nmi_i, lvl_mid_i, lvl_lo_i, ext_req_i} = '0;
    cyc();

    // R10 hold defers, R7 enable cleared afterwards
    enable();
    lvl_mid_i = 1'b1;
    nmi_i = 1'b1;
    cyc();
    hold_i = 1'b1;
    strobe();
    chk("R10 hold blocks", take_o, 0);
    hold_i = 1'b0;
    strobe();
    chk("R10 nmi after hold", src_o, 5'b00001);
    chk("R10 take", take_o, 1);
    strobe();
    chk("R7 disabled after grant", take_o, 0);
    nmi_i = 1'b0;
    enable();
    chk("R7 en cmd", ien_o, 1);
    dis_cmd_i = 1'b1; cyc(); dis_cmd_i = 1'b0;
    chk("R7 dis cmd", ien_o, 0);
    strobe();
    chk("R7 no grant disabled", take_o, 0);
    lvl_mid_i = 1'b0;

    // R2 R3 general acknowledge pulse
    enable();
    ext_req_i = 1'b1;
    strobe();
    chk("R2 ack low", ext_ack_n_o, 0);
    chk("R2 ext vec", vec_o, 16'h0000);
    ext_req_i = 1'b0;
    cyc();
    chk("R3 ack one cycle", ext_ack_n_o, 1);
    chk("R3 take one cycle", take_o, 0);
    chk("R3 src held", src_o, 5'b10000);

    // R12 reset mid-run
    enable();
    edge_hi_i = 1'b1; cyc(); edge_hi_i = 1'b0;
    do_reset();
    chk("R12 ien after reset", ien_o, 0);
    chk("R12 mask after reset", mask_o, 3'b111);
    chk("R12 latch after reset", pend_o[2], 0);
    chk("R12 src after reset", src_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule